// File: doc/BRIEF.md
# I2C Transfer Sequencer

This block runs whole I2C master transfers on top of a byte-level bus engine. It accepts one command: a 7-bit device address, a direction, up to `ADDR_BYTES` register-offset bytes, and a data length. It then walks the engine through each bus step. For every step it writes a control code, waits for the engine's completion flag, and compares the reported status code with the one that step should produce. Write data is pulled from a byte stream one byte at a time, and read data is pushed out one byte per cycle with a valid strobe.

A probe command checks whether a device is present. It addresses the device for reading, takes one dummy byte with NAK, and releases the bus. Every transfer ends with a STOP, including a transfer that failed part way. The result is a 32-bit word: zero on success, otherwise an error class, the control code last written, the status seen and the status that was expected. Timeouts are counted in periods of an external tick, one tick per bus clock period.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A write issues START (control 0x60, expects status 0x08), then the address byte {chip,0} (control 0x40, expects 0x18). Next come the offset bytes from index alen-1 down to 0, where byte k is addr_i[8k+7:8k]. Then come the data bytes. Each offset and data byte uses control 0x40 and expects 0x28. The transfer ends with STOP (control 0x50).
- R2: A read with alen>0 issues START (0x08), {chip,0} (0x18) and the offset bytes (0x28 each). It then issues a repeated START (control 0x60, expects 0x10) and {chip,1} (expects 0x40), with no STOP in between.
- R3: A read with alen=0 issues START (0x08) and then {chip,1} (0x40) directly.
- R4: Each received byte except the last is taken with control 0x44 (ACK, expects 0x50). The last byte is taken with control 0x40 (NAK, expects 0x58). Every received byte appears on rd_data_o with a one-cycle rd_valid_o, in bus order.
- R5: A probe issues START, {chip,1}, one NAKed receive and STOP. It returns zero when every status matches. The dummy byte is not delivered on rd_valid_o.
- R6: When a status mismatches, the result is {8'h01, last control, seen status, expected status}. No further bus step is issued except the final STOP.
- R7: When the flag has not risen after TIMEOUT_TICKS pulses of tick_i, the step fails with class 8'h02 in the same packed layout.
- R8: STOP completes when the engine status reads 0xF8. A STOP timeout reports {8'h02, 8'h50, status, 8'hF8}, but only when no earlier step failed. An earlier failure keeps its own code.
- R9: done_o pulses for one cycle at the end of every transfer, and result_o holds that transfer's code from then on. busy_o is high from the cycle after an accepted start until the done cycle.
- R10: start_i is ignored while busy_o is high. A start presented in the done cycle is accepted.
- R11: Each write data byte is taken from wr_data_i in the cycle wr_pop_o is high, one pop per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per bus clock period, for timeouts |
| start_i | input | 1 | Command strobe |
| probe_i | input | 1 | Command is a presence probe |
| rd_i | input | 1 | Command is a read (1) or write (0) |
| chip_i | input | 7 | Device address |
| alen_i | input | ALEN_W | Offset byte count, clamped to ADDR_BYTES |
| len_i | input | LEN_W | Data byte count |
| addr_i | input | 8*ADDR_BYTES | Offset bytes, byte k at bits 8k+7:8k |
| wr_data_i | input | 8 | Write data stream head |
| wr_pop_o | output | 1 | Write data byte consumed |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_data_o valid |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished, result_o valid |
| result_o | output | 32 | Packed result code |
| eng_we_o | output | 1 | Control write strobe to the byte engine |
| eng_ctrl_o | output | 8 | Control code to the engine |
| eng_data_o | output | 8 | Byte to transmit |
| eng_iflg_i | input | 1 | Engine step-complete flag |
| eng_status_i | input | 8 | Engine status code |
| eng_data_i | input | 8 | Engine received byte |

## Verification
The collision of interest is between a command request and the sequencer's own completion. The bench starts a write and, while it is still running, pulses start_i with a different device. It then checks at the bus steps that the running transfer is untouched and that only one done follows. The bench also raises the next start in the very cycle done_o is high. It then checks that busy_o rises one cycle later and that the second command's steps follow the first transfer's STOP.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    PH_START, PH_ADDR_W, PH_IDX, PH_RSTART, PH_ADDR_R, PH_WDATA, PH_RDATA, PH_STOP
  } phase_e;

  localparam logic [7:0] CTL_ACK   = 8'h04;
  localparam logic [7:0] CTL_STOP  = 8'h10;
  localparam logic [7:0] CTL_START = 8'h20;
  localparam logic [7:0] CTL_EN    = 8'h40;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NAK  = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  localparam logic [7:0] ERR_STATUS  = 8'h01;
  localparam logic [7:0] ERR_TIMEOUT = 8'h02;
endpackage

// File: rtl/i2c_seq_step.sv
module i2c_seq_step
  import i2c_seq_pkg::*;
(
  input  phase_e     phase_i,
  input  logic [6:0] chip_i,
  input  logic       rd_bit_i,
  input  logic [7:0] idx_byte_i,
  input  logic [7:0] wdata_i,
  input  logic       more_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic [7:0] expect_o
);
  always_comb begin
    ctrl_o   = CTL_EN;
    data_o   = 8'h00;
    expect_o = ST_IDLE;
    unique case (phase_i)
      PH_START:  begin ctrl_o = CTL_EN | CTL_START; expect_o = ST_START; end
      PH_RSTART: begin ctrl_o = CTL_EN | CTL_START; expect_o = ST_RSTART; end
      PH_ADDR_W: begin data_o = {chip_i, 1'b0}; expect_o = ST_AW_ACK; end
      PH_ADDR_R: begin data_o = {chip_i, rd_bit_i}; expect_o = ST_AR_ACK; end
      PH_IDX:    begin data_o = idx_byte_i; expect_o = ST_DW_ACK; end
      PH_WDATA:  begin data_o = wdata_i; expect_o = ST_DW_ACK; end
      PH_RDATA:  begin
        ctrl_o   = more_i ? (CTL_EN | CTL_ACK) : CTL_EN;
        expect_o = more_i ? ST_DR_ACK : ST_DR_NAK;
      end
      PH_STOP:   begin ctrl_o = CTL_EN | CTL_STOP; expect_o = ST_IDLE; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/i2c_seq_waiter.sv
module i2c_seq_waiter
  import i2c_seq_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       stop_mode_i,
  input  logic [7:0] expect_i,
  input  logic       tick_i,
  input  logic       iflg_i,
  input  logic [7:0] status_i,
  output logic       fin_o,
  output logic       err_o,
  output logic [7:0] cls_o
);
  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = stop_mode_i ? (status_i == ST_IDLE) : iflg_i;

  always_comb begin
    fin_o = 1'b0;
    err_o = 1'b0;
    cls_o = 8'h00;
    if (active_q) begin
      if (hit) begin
        fin_o = 1'b1;
        err_o = !stop_mode_i && (status_i != expect_i);
        cls_o = err_o ? ERR_STATUS : 8'h00;
      end else if (tick_i && cnt_q == CNT_LAST) begin
        fin_o = 1'b1;
        err_o = 1'b1;
        cls_o = ERR_TIMEOUT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (fin_o) begin
      active_q <= 1'b0;
    end else if (active_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_BYTES    = 4,
  parameter int ALEN_W        = 3,
  parameter int LEN_W         = 8,
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    start_i,
  input  logic                    probe_i,
  input  logic                    rd_i,
  input  logic [6:0]              chip_i,
  input  logic [ALEN_W-1:0]       alen_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  input  logic [7:0]              wr_data_i,
  output logic                    wr_pop_o,
  output logic [7:0]              rd_data_o,
  output logic                    rd_valid_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [31:0]             result_o,
  output logic                    eng_we_o,
  output logic [7:0]              eng_ctrl_o,
  output logic [7:0]              eng_data_o,
  input  logic                    eng_iflg_i,
  input  logic [7:0]              eng_status_i,
  input  logic [7:0]              eng_data_i
);
  localparam logic [ALEN_W-1:0] ALEN_MAX = ALEN_W'(ADDR_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e                  st_q;
  phase_e                  ph_q, ph_nxt;
  logic                    rd_q, probe_q;
  logic [6:0]              chip_q;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [ALEN_W-1:0]       idx_q, idx_sel;
  logic [LEN_W-1:0]        dcnt_q;
  logic [7:0]              last_ctrl_q, expect_q;
  logic                    stop_mode_q, err_q, done_q, rdv_q;
  logic [7:0]              rdd_q;
  logic [31:0]             res_q;
  logic [7:0]              idx_byte, step_ctrl, step_data, step_exp;
  logic                    w_fin, w_err;
  logic [7:0]              w_cls;
  phase_e                  tail_ph;

  assign idx_sel = idx_q - 1'b1;

  always_comb begin
    idx_byte = 8'h00;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx_sel == ALEN_W'(k)) idx_byte = addr_q[8*k +: 8];
  end

  i2c_seq_step u_step (
    .phase_i   (ph_q),
    .chip_i    (chip_q),
    .rd_bit_i  (1'b1),
    .idx_byte_i(idx_byte),
    .wdata_i   (wr_data_i),
    .more_i    (dcnt_q > LEN_W'(1)),
    .ctrl_o    (step_ctrl),
    .data_o    (step_data),
    .expect_o  (step_exp)
  );

  i2c_seq_waiter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (st_q == S_ISSUE),
    .stop_mode_i(stop_mode_q),
    .expect_i   (expect_q),
    .tick_i     (tick_i),
    .iflg_i     (eng_iflg_i),
    .status_i   (eng_status_i),
    .fin_o      (w_fin),
    .err_o      (w_err),
    .cls_o      (w_cls)
  );

  // phase after the offset bytes are exhausted
  assign tail_ph = rd_q ? PH_RSTART : ((dcnt_q != '0) ? PH_WDATA : PH_STOP);

  always_comb begin
    ph_nxt = PH_STOP;
    unique case (ph_q)
      PH_START:  ph_nxt = (probe_q || (rd_q && idx_q == '0)) ? PH_ADDR_R : PH_ADDR_W;
      PH_ADDR_W: ph_nxt = (idx_q != '0) ? PH_IDX : tail_ph;
      PH_IDX:    ph_nxt = (idx_q > ALEN_W'(1)) ? PH_IDX : tail_ph;
      PH_RSTART: ph_nxt = PH_ADDR_R;
      PH_ADDR_R: ph_nxt = (dcnt_q != '0) ? PH_RDATA : PH_STOP;
      PH_WDATA:  ph_nxt = (dcnt_q > LEN_W'(1)) ? PH_WDATA : PH_STOP;
      PH_RDATA:  ph_nxt = (dcnt_q > LEN_W'(1)) ? PH_RDATA : PH_STOP;
      default:   ph_nxt = PH_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      ph_q        <= PH_START;
      rd_q        <= 1'b0;
      probe_q     <= 1'b0;
      chip_q      <= '0;
      addr_q      <= '0;
      idx_q       <= '0;
      dcnt_q      <= '0;
      last_ctrl_q <= '0;
      expect_q    <= '0;
      stop_mode_q <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      rdv_q       <= 1'b0;
      rdd_q       <= '0;
      res_q       <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q    <= S_ISSUE;
          ph_q    <= PH_START;
          probe_q <= probe_i;
          rd_q    <= rd_i | probe_i;
          chip_q  <= chip_i;
          addr_q  <= addr_i;
          idx_q   <= probe_i ? '0 : ((alen_i > ALEN_MAX) ? ALEN_MAX : alen_i);
          dcnt_q  <= probe_i ? LEN_W'(1) : len_i;
          err_q   <= 1'b0;
          res_q   <= '0;
        end
        S_ISSUE: begin
          st_q        <= S_WAIT;
          last_ctrl_q <= step_ctrl;
          expect_q    <= step_exp;
          stop_mode_q <= (ph_q == PH_STOP);
        end
        S_WAIT: if (w_fin) begin
          if (ph_q == PH_STOP) begin
            if (w_err && !err_q) res_q <= {w_cls, last_ctrl_q, eng_status_i, expect_q};
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (w_err) begin
            err_q <= 1'b1;
            res_q <= {w_cls, last_ctrl_q, eng_status_i, expect_q};
            ph_q  <= PH_STOP;
            st_q  <= S_ISSUE;
          end else begin
            if (ph_q == PH_IDX) idx_q <= idx_q - 1'b1;
            if (ph_q == PH_WDATA || ph_q == PH_RDATA) dcnt_q <= dcnt_q - 1'b1;
            if (ph_q == PH_RDATA && !probe_q) begin
              rdv_q <= 1'b1;
              rdd_q <= eng_data_i;
            end
            ph_q <= ph_nxt;
            st_q <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign eng_we_o   = (st_q == S_ISSUE);
  assign eng_ctrl_o = step_ctrl;
  assign eng_data_o = step_data;
  assign wr_pop_o   = (st_q == S_ISSUE) && (ph_q == PH_WDATA);
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign result_o   = res_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdd_q;
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] result_o,
  input logic        eng_we_o,
  input logic [7:0]  eng_ctrl_o,
  input logic        eng_iflg_i,
  input logic        rd_valid_o,
  input logic        wr_pop_o
);
  logic [7:0] last_ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_ctl_q <= 8'h00;
    else if (eng_we_o) last_ctl_q <= eng_ctrl_o;
  end

  a_r1_step_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_o |=> !eng_we_o);

  a_r8_stop_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> last_ctl_q == 8'h50);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r6_result_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o != 32'h0) |-> (result_o[31:24] == 8'h01 || result_o[31:24] == 8'h02));

  a_r4_rd_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(eng_iflg_i));

  a_r11_pop_on_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pop_o |-> (eng_we_o && eng_ctrl_o == 8'h40));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .eng_we_o   (eng_we_o),
  .eng_ctrl_o (eng_ctrl_o),
  .eng_iflg_i (eng_iflg_i),
  .rd_valid_o (rd_valid_o),
  .wr_pop_o   (wr_pop_o)
);

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, probe_i = 1'b0, rd_i = 1'b0;
  logic [6:0]  chip_i = '0;
  logic [2:0]  alen_i = '0;
  logic [7:0]  len_i = '0;
  logic [31:0] addr_i = '0;
  logic [7:0]  wr_data_i;
  logic        wr_pop_o, rd_valid_o, busy_o, done_o, eng_we_o;
  logic [7:0]  rd_data_o, eng_ctrl_o, eng_data_o;
  logic [31:0] result_o;
  logic        eng_iflg_i = 1'b0;
  logic [7:0]  eng_status_i = 8'hF8;
  logic [7:0]  eng_data_i = 8'h00;

  always #5 clk_i = ~clk_i;

  i2c_xfer_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(1'b1), .start_i(start_i),
    .probe_i(probe_i), .rd_i(rd_i), .chip_i(chip_i), .alen_i(alen_i),
    .len_i(len_i), .addr_i(addr_i), .wr_data_i(wr_data_i), .wr_pop_o(wr_pop_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .eng_we_o(eng_we_o),
    .eng_ctrl_o(eng_ctrl_o), .eng_data_o(eng_data_o), .eng_iflg_i(eng_iflg_i),
    .eng_status_i(eng_status_i), .eng_data_i(eng_data_i)
  );

  // byte engine model
  logic       mdl_clr = 1'b0;
  int         hang_step = -1;
  bit         stop_hang = 1'b0, absent = 1'b0;
  logic [7:0] log_c [64];
  logic [7:0] log_d [64];
  logic [7:0] rbytes [16];
  int         nlog, nrd, ndone, wcnt, rcnt, pcnt;
  bit         in_txn, after_start, reading, pflag;
  logic [7:0] pstat, pdat;

  assign wr_data_i = 8'hD0 + 8'(wcnt);

  always @(posedge clk_i) begin
    logic [7:0] s;
    if (mdl_clr) begin
      nlog <= 0; nrd <= 0; ndone <= 0; wcnt <= 0; rcnt <= 0; pcnt <= 0;
      in_txn <= 0; after_start <= 0; reading <= 0; eng_iflg_i <= 0;
    end else begin
      if (pcnt == 1) begin eng_status_i <= pstat; eng_iflg_i <= pflag; eng_data_i <= pdat; end
      if (pcnt > 0) pcnt <= pcnt - 1;
      if (done_o) ndone <= ndone + 1;
      if (wr_pop_o) wcnt <= wcnt + 1;
      if (rd_valid_o) begin rbytes[nrd[3:0]] <= rd_data_o; nrd <= nrd + 1; end
      if (eng_we_o) begin
        log_c[nlog[5:0]] <= eng_ctrl_o;
        log_d[nlog[5:0]] <= eng_data_o;
        nlog <= nlog + 1;
        eng_iflg_i <= 1'b0;
        pdat <= 8'h00;
        if (eng_ctrl_o[4]) begin
          s = 8'hF8; in_txn <= 0; reading <= 0;
        end else if (eng_ctrl_o[5]) begin
          s = in_txn ? 8'h10 : 8'h08; in_txn <= 1; after_start <= 1;
        end else if (after_start) begin
          after_start <= 0;
          if (absent) s = eng_data_o[0] ? 8'h48 : 8'h20;
          else s = eng_data_o[0] ? 8'h40 : 8'h18;
          reading <= eng_data_o[0] && !absent;
        end else if (reading) begin
          s = eng_ctrl_o[2] ? 8'h50 : 8'h58;
          pdat <= 8'hA0 + 8'(rcnt); rcnt <= rcnt + 1;
        end else s = 8'h28;
        pstat <= s;
        pflag <= !eng_ctrl_o[4];
        if (nlog == hang_step || (eng_ctrl_o[4] && stop_hang)) pcnt <= 0;
        else pcnt <= 3;
      end
    end
  end

  int tests = 0, fails = 0, cyc = 0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // compare the step log against an expected list; data checked where mask bit set
  task automatic chk_log(input string req, input int n, input logic [7:0] c[], input logic [7:0] d[], input bit m[]);
    bit ok = (nlog == n);
    for (int i = 0; i < n && i < 64; i++) begin
      if (log_c[i] !== c[i]) ok = 0;
      if (m[i] && log_d[i] !== d[i]) ok = 0;
    end
    chk(ok, req, {24'h0, 8'(nlog)}, {24'h0, 8'(n)});
    if (!ok)
      for (int i = 0; i < nlog && i < 64; i++)
        $display("  step %0d ctrl %h data %h", i, log_c[i], log_d[i]);
  endtask

  task automatic clear_model(input int hs, input bit sh, input bit ab);
    hang_step = hs; stop_hang = sh; absent = ab;
    @(negedge clk_i) mdl_clr = 1'b1;
    @(negedge clk_i) mdl_clr = 1'b0;
  endtask

  task automatic issue(input bit pr, input bit rd, input logic [6:0] ch, input logic [2:0] al,
                       input logic [31:0] ad, input logic [7:0] ln);
    @(negedge clk_i);
    probe_i = pr; rd_i = rd; chip_i = ch; alen_i = al; addr_i = ad; len_i = ln; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 5000) begin @(negedge clk_i); n++; end
    chk(done_o === 1'b1, req, {31'h0, done_o}, 32'h1);
  endtask

  task automatic t_reset;
    chk_eq("R9 reset busy", {31'h0, busy_o}, 32'h0);
    chk_eq("R9 reset done", {31'h0, done_o}, 32'h0);
    chk_eq("R9 reset result", result_o, 32'h0);
    chk_eq("R1 reset we", {31'h0, eng_we_o}, 32'h0);
  endtask

  task automatic t_write;
    clear_model(-1, 0, 0);
    issue(0, 0, 7'h50, 3'd2, 32'h0000_1234, 8'd2);
    chk_eq("R9 busy after start", {31'h0, busy_o}, 32'h1);
    wait_done("R9 write done");
    chk_eq("R1 write result", result_o, 32'h0);
    chk_log("R1 write steps", 7, '{8'h60, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h50},
            '{8'h00, 8'hA0, 8'h12, 8'h34, 8'hD0, 8'hD1, 8'h00}, '{0, 1, 1, 1, 1, 1, 0});
    chk_eq("R11 pops", 32'(wcnt), 32'd2);
    @(negedge clk_i);
    chk_eq("R9 done one cycle", {31'h0, done_o}, 32'h0);
    chk_eq("R9 result held", result_o, 32'h0);
  endtask

  task automatic t_read_off;
    clear_model(-1, 0, 0);
    issue(0, 1, 7'h3C, 3'd1, 32'h0000_0007, 8'd3);
    wait_done("R2 read done");
    chk_eq("R2 read result", result_o, 32'h0);
    chk_log("R2 R4 read steps", 9,
            '{8'h60, 8'h40, 8'h40, 8'h60, 8'h40, 8'h44, 8'h44, 8'h40, 8'h50},
            '{8'h00, 8'h78, 8'h07, 8'h00, 8'h79, 8'h00, 8'h00, 8'h00, 8'h00},
            '{0, 1, 1, 0, 1, 0, 0, 0, 0});
    chk_eq("R4 read count", 32'(nrd), 32'd3);
    chk_eq("R4 read bytes", {8'h0, rbytes[0], rbytes[1], rbytes[2]}, 32'h00A0A1A2);
  endtask

  task automatic t_read_direct;
    clear_model(-1, 0, 0);
    issue(0, 1, 7'h21, 3'd0, 32'h0, 8'd1);
    wait_done("R3 read done");
    chk_eq("R3 result", result_o, 32'h0);
    chk_log("R3 R4 direct steps", 4, '{8'h60, 8'h40, 8'h40, 8'h50},
            '{8'h00, 8'h43, 8'h00, 8'h00}, '{0, 1, 0, 0});
    chk_eq("R4 single byte", {24'h0, rbytes[0]}, 32'hA0);
  endtask

  task automatic t_probe;
    clear_model(-1, 0, 0);
    issue(1, 0, 7'h48, 3'd2, 32'hFFFF, 8'd5);
    wait_done("R5 probe done");
    chk_eq("R5 probe present", result_o, 32'h0);
    chk_log("R5 probe steps", 4, '{8'h60, 8'h40, 8'h40, 8'h50},
            '{8'h00, 8'h91, 8'h00, 8'h00}, '{0, 1, 0, 0});
    chk_eq("R5 dummy not delivered", 32'(nrd), 32'd0);
    clear_model(-1, 0, 1);
    issue(1, 0, 7'h48, 3'd0, 32'h0, 8'd0);
    wait_done("R5 probe absent done");
    chk_eq("R5 R6 probe absent code", result_o, 32'h01404840);
    chk_log("R6 probe absent steps", 3, '{8'h60, 8'h40, 8'h50},
            '{8'h00, 8'h91, 8'h00}, '{0, 1, 0});
  endtask

  task automatic t_wrong_status;
    clear_model(-1, 0, 1);
    issue(0, 0, 7'h50, 3'd1, 32'h55, 8'd1);
    wait_done("R6 nak done");
    chk_eq("R6 write nak code", result_o, 32'h01402018);
    chk_log("R6 abort to stop", 3, '{8'h60, 8'h40, 8'h50},
            '{8'h00, 8'hA0, 8'h00}, '{0, 1, 0});
    chk_eq("R11 no pop after abort", 32'(wcnt), 32'd0);
  endtask

  task automatic t_timeout;
    clear_model(2, 0, 0);
    issue(0, 0, 7'h10, 3'd1, 32'h55, 8'd1);
    wait_done("R7 timeout done");
    chk_eq("R7 timeout code", result_o, 32'h02401828);
    chk_log("R7 steps then stop", 4, '{8'h60, 8'h40, 8'h40, 8'h50},
            '{8'h00, 8'h20, 8'h55, 8'h00}, '{0, 1, 1, 0});
  endtask

  task automatic t_stop_timeout;
    clear_model(-1, 1, 0);
    issue(0, 0, 7'h11, 3'd0, 32'h0, 8'd1);
    wait_done("R8 stop timeout done");
    chk_eq("R8 stop timeout code", result_o, 32'h025028F8);
    clear_model(-1, 1, 1);
    issue(0, 0, 7'h50, 3'd0, 32'h0, 8'd1);
    wait_done("R8 precedence done");
    chk_eq("R8 first error kept", result_o, 32'h01402018);
  endtask

  task automatic t_collide;
    clear_model(-1, 0, 0);
    issue(0, 0, 7'h50, 3'd0, 32'h0, 8'd1);
    repeat (4) @(negedge clk_i);
    chip_i = 7'h7F; rd_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done("R10 first done");
    // start presented in the done cycle
    probe_i = 0; rd_i = 1; chip_i = 7'h21; alen_i = 0; len_i = 1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk_eq("R10 start in done cycle accepted", {31'h0, busy_o}, 32'h1);
    wait_done("R10 second done");
    chk_log("R10 busy start ignored", 8,
            '{8'h60, 8'h40, 8'h40, 8'h50, 8'h60, 8'h40, 8'h40, 8'h50},
            '{8'h00, 8'hA0, 8'hD0, 8'h00, 8'h00, 8'h43, 8'h00, 8'h00},
            '{0, 1, 1, 0, 0, 1, 0, 0});
    @(negedge clk_i);
    chk_eq("R10 done count", 32'(ndone), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_write();
    t_read_off();
    t_read_direct();
    t_probe();
    t_wrong_status();
    t_timeout();
    t_stop_timeout();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule